// File: doc/BRIEF.md
# Key-Guarded Byte Storage Controller

This block sits on a simple register bus inside a microcontroller and fronts a small byte-wide nonvolatile data store. Software sees four registers: ADDR (the byte location), DATA (the byte to store or the byte last fetched), CTRL (command and status bits) and KEY (a write-only guard register). A fetch completes in the same bus access that asks for it. A store takes a fixed number of clock cycles. It begins only when writes are enabled and the KEY register has just received a two-byte unlock pattern.

Two reset inputs exist. The power-on reset clears every register. The warm reset stands for an external reset pin or a watchdog expiry. It abandons any store in progress and records that fact in a sticky ABORT bit. ADDR and DATA keep their contents, so software can retry the same byte afterwards. A DONE flag, also driven out as an interrupt line, marks each completed store. The storage array itself is never cleared by either reset.

Top module: `nvm_keyed_ctrl`

## Requirements
- R1: Register select 0 is ADDR, 1 is DATA, 2 is CTRL and 3 is KEY. ADDR reads back zero-extended from ADDR_W bits. KEY reads 0 whatever was written to it. CTRL reads {3'b000, DONE, ABORT, PROG_EN, PROG, LOAD}: LOAD is bit 0 and always reads 0, PROG is bit 1, PROG_EN is bit 2, ABORT is bit 3 and DONE is bit 4.
- R2: A CTRL write with bit 0 set, made while no store is running and not itself starting one, copies the array byte at ADDR into DATA. The byte is readable from DATA on the next cycle. DATA otherwise changes only on a bus write to DATA.
- R3: Writing 0 to PROG has no effect. Once PROG is set it stays 1 until its store finishes or a reset occurs.
- R4: PROG_EN takes the value of bit 2 on every CTRL write and is never changed by hardware except through a reset. PROG can be set only if PROG_EN was already 1 before that access. Clearing PROG_EN while a store runs does not stop the store.
- R5: A store starts only when the KEY register receives 55h and then AAh, and the next bus write is a CTRL write with bit 1 set. Any other bus write in between cancels the pattern: a different KEY value, or a write to ADDR, DATA or CTRL. A fresh 55h restarts the pattern at its first step. Every store needs a new pattern.
- R6: After the starting access, PROG reads 1 for exactly PROG_CYCLES cycles. The array byte is then written with the ADDR and DATA values held at the start.
- R7: When a store finishes, PROG clears and DONE sets. DONE, which drives done_irq, and ABORT are each cleared by a CTRL write with that bit at 0. Writing 1 to either has no effect.
- R8: A load request (CTRL bit 0) made while a store runs is ignored, and DATA is unchanged.
- R9: A warm reset abandons a running store: the array is not written and ABORT is set. With no store running, ABORT keeps its value. PROG, PROG_EN, DONE and the key pattern clear. ADDR and DATA keep their values, and bus writes in the reset cycle are ignored.
- R10: The power-on reset clears ADDR, DATA, PROG, PROG_EN, ABORT, DONE and the key pattern. Array contents survive it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_por | input | 1 | Synchronous power-on reset, active high, clears everything but the array |
| rst_warm | input | 1 | Synchronous warm reset (pin or watchdog), active high |
| bus_we | input | 1 | Register write strobe for one cycle |
| bus_sel | input | 2 | Register select: 0 ADDR, 1 DATA, 2 CTRL, 3 KEY |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| done_irq | output | 1 | Store-complete flag (DONE) |

## Verification
The bench checks a store whose key pattern is broken at each step: by a write to another register, by a wrong key byte, by a repeated 55h, and by a CTRL write that does not set PROG. A design that remembered the pattern too long would start a store that should never happen. It also clears PROG, clears PROG_EN and asks for a load while a store is in flight, and moves ADDR away during the store. Erring here would cut the store short, fetch over DATA, or write to the wrong byte. A warm reset is applied both during a store and when idle, to catch a design that lands the aborted byte, loses ADDR or DATA, or raises ABORT when nothing was running.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_e;

    localparam int B_LOAD    = 0;
    localparam int B_PROG    = 1;
    localparam int B_PROG_EN = 2;
    localparam int B_ABORT   = 3;
    localparam int B_DONE    = 4;

    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_HALF  = 2'd1,
        K_ARMED = 2'd2
    } key_state_e;

    typedef struct packed {
        logic done;
        logic abort;
        logic prog_en;
        logic prog;
    } ctrl_view_t;

    function automatic logic [BYTE_W-1:0] pack_ctrl(ctrl_view_t c);
        return {3'b000, c.done, c.abort, c.prog_en, c.prog, 1'b0};
    endfunction

    function automatic key_state_e key_step(key_state_e cur, logic [BYTE_W-1:0] v);
        if (v == KEY_FIRST) begin
            return K_HALF;
        end
        if (v == KEY_SECOND && cur == K_HALF) begin
            return K_ARMED;
        end
        return K_IDLE;
    endfunction

endpackage

// File: rtl/nvm_key_fsm.sv
module nvm_key_fsm
    import nvm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic              armed
);
    key_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= K_IDLE;
        end else if (bus_we) begin
            if (sel == SEL_KEY) begin
                state_q <= key_step(state_q, wdata);
            end else begin
                state_q <= K_IDLE;
            end
        end
    end

    assign armed = (state_q == K_ARMED);
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic finish
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign finish = busy && (cnt_q == '0);
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_keyed_ctrl.sv
module nvm_keyed_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int PROG_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_por,
    input  logic       rst_warm,
    input  logic       bus_we,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       done_irq
);
    reg_sel_e          sel;
    logic              rst_any;
    logic              armed;
    logic              busy;
    logic              finish;
    logic              start;
    logic              load;
    logic              ctrl_wr;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [ADDR_W-1:0] prog_addr_q;
    logic [BYTE_W-1:0] prog_data_q;
    logic              prog_en_q;
    logic              abort_q;
    logic              done_q;
    logic [BYTE_W-1:0] cell_rd;
    logic              cell_we;
    ctrl_view_t        view;

    assign sel     = reg_sel_e'(bus_sel);
    assign rst_any = rst_por | rst_warm;
    assign ctrl_wr = bus_we && (sel == SEL_CTRL);
    assign start   = ctrl_wr && bus_wdata[B_PROG] && prog_en_q && armed && !busy;
    assign load    = ctrl_wr && bus_wdata[B_LOAD] && !busy && !start;
    assign cell_we = finish && !rst_any;

    nvm_key_fsm u_key (
        .clk    (clk),
        .rst    (rst_any),
        .bus_we (bus_we),
        .sel    (sel),
        .wdata  (bus_wdata),
        .armed  (armed)
    );

    nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst_any),
        .start  (start),
        .busy   (busy),
        .finish (finish)
    );

    nvm_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk   (clk),
        .we    (cell_we),
        .waddr (prog_addr_q),
        .wdata (prog_data_q),
        .raddr (addr_q),
        .rdata (cell_rd)
    );

    always_ff @(posedge clk) begin
        if (rst_por) begin
            addr_q      <= '0;
            data_q      <= '0;
            prog_addr_q <= '0;
            prog_data_q <= '0;
            prog_en_q   <= 1'b0;
            abort_q     <= 1'b0;
            done_q      <= 1'b0;
        end else if (rst_warm) begin
            if (busy) begin
                abort_q <= 1'b1;
            end
            prog_en_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            if (bus_we && sel == SEL_ADDR) begin
                addr_q <= bus_wdata[ADDR_W-1:0];
            end
            if (bus_we && sel == SEL_DATA) begin
                data_q <= bus_wdata;
            end else if (load) begin
                data_q <= cell_rd;
            end
            if (ctrl_wr) begin
                prog_en_q <= bus_wdata[B_PROG_EN];
                if (!bus_wdata[B_ABORT]) begin
                    abort_q <= 1'b0;
                end
                if (!bus_wdata[B_DONE]) begin
                    done_q <= 1'b0;
                end
            end
            if (finish) begin
                done_q <= 1'b1;
            end
            if (start) begin
                prog_addr_q <= addr_q;
                prog_data_q <= data_q;
            end
        end
    end

    always_comb begin
        view.done    = done_q;
        view.abort   = abort_q;
        view.prog_en = prog_en_q;
        view.prog    = busy;
        case (sel)
            SEL_ADDR: bus_rdata = BYTE_W'(addr_q);
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: bus_rdata = pack_ctrl(view);
            default:  bus_rdata = '0;
        endcase
    end

    assign done_irq = done_q;
endmodule

// File: rtl/nvm_keyed_ctrl_chk.sv
module nvm_keyed_ctrl_chk #(
    parameter int ADDR_W      = 6,
    parameter int PROG_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_por,
    input logic              rst_warm,
    input logic              bus_we,
    input logic [1:0]        bus_sel,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              done_irq,
    input logic              busy,
    input logic              armed,
    input logic              prog_en_q,
    input logic              abort_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [7:0]        data_q
);
    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst_por || rst_warm || !busy) begin
            run_cnt <= 0;
        end else begin
            run_cnt <= run_cnt + 1;
        end
    end

    // R1
    a_r1_ctrl_spare_zero: assert property (@(posedge clk) disable iff (rst_por)
        (bus_sel == 2'd2) |-> (bus_rdata[7:5] == 3'b000 && bus_rdata[0] == 1'b0));

    // R1
    a_r1_key_reads_zero: assert property (@(posedge clk) disable iff (rst_por)
        (bus_sel == 2'd3) |-> (bus_rdata == 8'h00));

    // R4
    a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
        $rose(busy) |-> $past(prog_en_q));

    // R5
    a_r5_start_needs_key: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
        $rose(busy) |-> $past(armed && bus_we && bus_sel == 2'd2 && bus_wdata[1]));

    // R3
    a_r3_prog_holds: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
        (busy && run_cnt < PROG_CYCLES - 1) |=> busy);

    // R6
    a_r6_prog_length: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
        busy |-> (run_cnt < PROG_CYCLES));

    // R7
    a_r7_done_on_finish: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
        (busy && run_cnt == PROG_CYCLES - 1) |=> (done_irq && !busy));

    // R8
    a_r8_load_ignored_busy: assert property (@(posedge clk) disable iff (rst_por)
        (busy && !(bus_we && bus_sel == 2'd1)) |=> $stable(data_q));

    // R9
    a_r9_warm_sets_abort: assert property (@(posedge clk) disable iff (rst_por)
        (rst_warm && busy) |=> (abort_q && !busy));

    // R9
    a_r9_warm_keeps_regs: assert property (@(posedge clk) disable iff (rst_por)
        rst_warm |=> ($stable(addr_q) && $stable(data_q)));

    // R10
    a_r10_por_clears: assert property (@(posedge clk) disable iff (rst_warm)
        rst_por |=> (addr_q == '0 && data_q == 8'h00 && !abort_q && !busy && !prog_en_q && !done_irq));
endmodule

bind nvm_keyed_ctrl nvm_keyed_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .PROG_CYCLES (PROG_CYCLES)
) chk_i (
    .clk       (clk),
    .rst_por   (rst_por),
    .rst_warm  (rst_warm),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done_irq  (done_irq),
    .busy      (busy),
    .armed     (armed),
    .prog_en_q (prog_en_q),
    .abort_q   (abort_q),
    .addr_q    (addr_q),
    .data_q    (data_q)
);

// File: tb/nvm_keyed_ctrl_tb_top.sv
module nvm_keyed_ctrl_tb_top;
    localparam int AW    = 6;
    localparam int NCYC  = 16;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rst_por = 1'b1;
    logic       rst_warm = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       done_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    nvm_keyed_ctrl #(.ADDR_W(AW), .PROG_CYCLES(NCYC)) dut_i (
        .clk       (clk),
        .rst_por   (rst_por),
        .rst_warm  (rst_warm),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done_irq  (done_irq)
    );

    // ---------------- behavioural reference model ----------------
    bit         m_live = 0;
    logic [7:0] m_addr, m_data, m_pd;
    int         m_pa;
    bit         m_dk, m_wr, m_en, m_abort, m_done;
    int         m_key, m_cnt;
    logic [7:0] m_mem [DEPTH];
    bit         m_known [DEPTH];

    task automatic model_step();
        int  p_addr;
        logic [7:0] p_data;
        bit  p_wr, p_en, fin, strt, ld;
        int  p_key;
        if (rst_por) begin
            m_live = 1; m_addr = 0; m_data = 0; m_dk = 1; m_wr = 0; m_en = 0;
            m_abort = 0; m_done = 0; m_key = 0; m_cnt = 0;
            return;
        end
        if (!m_live) return;
        if (rst_warm) begin
            if (m_wr) m_abort = 1;
            m_wr = 0; m_en = 0; m_done = 0; m_key = 0; m_cnt = 0;
            return;
        end
        p_addr = int'(m_addr); p_data = m_data; p_wr = m_wr; p_en = m_en; p_key = m_key;
        fin = m_wr && (m_cnt == 0);
        if (m_wr) begin
            if (fin) begin
                m_mem[m_pa] = m_pd; m_known[m_pa] = 1; m_wr = 0;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        if (bus_we) begin
            case (bus_sel)
                2'd0: begin m_addr = bus_wdata & 8'((DEPTH) - 1); m_key = 0; end
                2'd1: begin m_data = bus_wdata; m_dk = 1; m_key = 0; end
                2'd2: begin
                    strt = bus_wdata[1] && p_en && (p_key == 2) && !p_wr;
                    ld   = bus_wdata[0] && !p_wr && !strt;
                    if (ld) begin m_data = m_mem[p_addr]; m_dk = m_known[p_addr]; end
                    if (strt) begin m_wr = 1; m_cnt = NCYC - 1; m_pa = p_addr; m_pd = p_data; end
                    m_en = bus_wdata[2];
                    if (!bus_wdata[3]) m_abort = 0;
                    if (!bus_wdata[4]) m_done = 0;
                    m_key = 0;
                end
                default: begin
                    if (bus_wdata == 8'h55) m_key = 1;
                    else if (bus_wdata == 8'hAA && p_key == 1) m_key = 2;
                    else m_key = 0;
                end
            endcase
        end
        if (fin) m_done = 1;
    endtask

    function automatic logic [7:0] model_rd(logic [1:0] s);
        case (s)
            2'd0:    return m_addr;
            2'd1:    return m_data;
            2'd2:    return {3'b000, m_done, m_abort, m_en, m_wr, 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic string sel_tag(logic [1:0] s);
        case (s)
            2'd0:    return "R10 model ADDR";
            2'd1:    return "R2 model DATA";
            2'd2:    return "R6 model CTRL";
            default: return "R1 model KEY";
        endcase
    endfunction

    always @(posedge clk) begin
        model_step();
        #2;
        if (m_live && !finished) begin
            if (!(bus_sel == 2'd1 && !m_dk))
                check8(sel_tag(bus_sel), bus_rdata, model_rd(bus_sel));
            check8("R7 model done_irq", {7'd0, done_irq}, {7'd0, m_done});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bw(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    endtask

    task automatic rd_chk(input logic [1:0] s, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_sel = s;
        #1;
        check8(tag, bus_rdata, exp);
    endtask

    task automatic unlock();
        bw(2'd3, 8'h55);
        bw(2'd3, 8'hAA);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            bus_we = 1'b0; bus_sel = 2'd2;
            #1;
            if (!bus_rdata[1]) break;
        end
    endtask

    task automatic warm_pulse(input bit with_write);
        @(negedge clk);
        rst_warm = 1'b1;
        bus_we = with_write; bus_sel = 2'd0; bus_wdata = 8'h2A;
        @(negedge clk);
        rst_warm = 1'b0; bus_we = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        int high_cycles;
        repeat (3) @(negedge clk);
        rst_por = 1'b0;

        // reset state
        rd_chk(2'd0, 8'h00, "R10 addr after power-on");
        rd_chk(2'd1, 8'h00, "R10 data after power-on");
        rd_chk(2'd2, 8'h00, "R10 ctrl after power-on");
        rd_chk(2'd3, 8'h00, "R1 key reads zero");

        bw(2'd0, 8'hFF);
        rd_chk(2'd0, 8'h3F, "R1 addr zero-extended");
        bw(2'd3, 8'h55);
        rd_chk(2'd3, 8'h00, "R1 key has no storage");
        bw(2'd0, 8'h05);
        bw(2'd1, 8'h3C);
        rd_chk(2'd1, 8'h3C, "R2 data holds bus write");

        // start attempt with enable low
        unlock();
        bw(2'd2, 8'h02);
        rd_chk(2'd2, 8'h00, "R4 prog blocked without enable");

        // first store, measured
        bw(2'd2, 8'h04);
        rd_chk(2'd2, 8'h04, "R4 enable written");
        unlock();
        bw(2'd2, 8'h06);
        high_cycles = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            bus_we = 1'b0; bus_sel = 2'd2;
            #1;
            if (bus_rdata[1]) high_cycles++;
            else break;
        end
        check8("R6 prog busy length", 8'(high_cycles), 8'(NCYC));
        #1;
        check8("R7 ctrl after store", bus_rdata, 8'h14);
        check8("R7 done_irq after store", {7'd0, done_irq}, 8'h01);
        bw(2'd2, 8'h14);
        rd_chk(2'd2, 8'h14, "R7 writing 1 keeps done");
        bw(2'd2, 8'h04);
        rd_chk(2'd2, 8'h04, "R7 done cleared by 0");
        bw(2'd1, 8'h00);
        bw(2'd2, 8'h05);
        rd_chk(2'd1, 8'h3C, "R2 load fetches stored byte");
        rd_chk(2'd2, 8'h04, "R1 load bit reads zero");

        // second store with in-flight disturbance
        bw(2'd0, 8'h09);
        bw(2'd1, 8'hA5);
        unlock();
        bw(2'd2, 8'h06);
        rd_chk(2'd2, 8'h06, "R5 store started by pattern");
        bw(2'd2, 8'h04);
        rd_chk(2'd2, 8'h06, "R3 prog not clearable");
        bw(2'd2, 8'h00);
        rd_chk(2'd2, 8'h02, "R4 enable clear keeps store");
        bw(2'd0, 8'h05);
        bw(2'd2, 8'h01);
        rd_chk(2'd1, 8'hA5, "R8 load ignored while busy");
        bw(2'd0, 8'h09);
        wait_idle();
        rd_chk(2'd2, 8'h10, "R7 done after second store");
        bw(2'd2, 8'h01);
        rd_chk(2'd1, 8'hA5, "R6 latched data landed at 9");
        bw(2'd0, 8'h05);
        bw(2'd2, 8'h01);
        rd_chk(2'd1, 8'h3C, "R6 location 5 untouched");

        // enable set in the same access as prog
        unlock();
        bw(2'd2, 8'h06);
        rd_chk(2'd2, 8'h04, "R4 enable must precede prog");

        // broken patterns
        bw(2'd0, 8'h07);
        bw(2'd1, 8'h11);
        bw(2'd3, 8'h55);
        bw(2'd1, 8'h11);
        bw(2'd3, 8'hAA);
        bw(2'd2, 8'h06);
        rd_chk(2'd2, 8'h04, "R5 other register breaks pattern");
        bw(2'd3, 8'h55);
        bw(2'd3, 8'h12);
        bw(2'd3, 8'hAA);
        bw(2'd2, 8'h06);
        rd_chk(2'd2, 8'h04, "R5 wrong key byte breaks pattern");
        bw(2'd3, 8'h55);
        bw(2'd3, 8'h55);
        bw(2'd3, 8'hAA);
        bw(2'd2, 8'h06);
        rd_chk(2'd2, 8'h06, "R5 repeated first byte restarts");
        wait_idle();
        rd_chk(2'd2, 8'h14, "R7 done after third store");
        warm_pulse(1'b0);
        rd_chk(2'd2, 8'h00, "R9 idle warm clears enable and done");
        bw(2'd2, 8'h04);
        bw(2'd2, 8'h06);
        rd_chk(2'd2, 8'h04, "R5 each store needs new pattern");
        unlock();
        bw(2'd2, 8'h04);
        bw(2'd2, 8'h06);
        rd_chk(2'd2, 8'h04, "R5 ctrl write consumes pattern");
        bw(2'd2, 8'h01);
        rd_chk(2'd1, 8'h11, "R6 third store landed at 7");

        // warm reset during a store
        bw(2'd2, 8'h04);
        bw(2'd0, 8'h09);
        bw(2'd1, 8'h77);
        unlock();
        bw(2'd2, 8'h06);
        rd_chk(2'd2, 8'h06, "R5 store running before warm");
        rd_chk(2'd2, 8'h06, "R3 still running");
        warm_pulse(1'b1);
        rd_chk(2'd2, 8'h08, "R9 abort set by warm reset");
        rd_chk(2'd0, 8'h09, "R9 addr kept and write ignored");
        rd_chk(2'd1, 8'h77, "R9 data kept");
        check8("R9 done_irq low after abort", {7'd0, done_irq}, 8'h00);
        bw(2'd2, 8'h09);
        rd_chk(2'd1, 8'hA5, "R9 array not written by aborted store");
        rd_chk(2'd2, 8'h08, "R7 writing 1 keeps abort");
        warm_pulse(1'b0);
        rd_chk(2'd2, 8'h08, "R9 idle warm keeps abort");
        bw(2'd2, 8'h00);
        rd_chk(2'd2, 8'h00, "R7 abort cleared by 0");

        // power-on reset again
        bw(2'd0, 8'h03);
        bw(2'd1, 8'h5A);
        @(negedge clk);
        bus_we = 1'b0; rst_por = 1'b1;
        repeat (2) @(negedge clk);
        rst_por = 1'b0;
        rd_chk(2'd0, 8'h00, "R10 addr cleared");
        rd_chk(2'd1, 8'h00, "R10 data cleared");
        rd_chk(2'd2, 8'h00, "R10 ctrl cleared");
        bw(2'd0, 8'h09);
        bw(2'd2, 8'h01);
        rd_chk(2'd1, 8'hA5, "R10 array survives power-on");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule